// File: doc/BRIEF.md
# Pin-Strap Configuration Decoder

This block works out, once after each reset, how five strap lines are wired on the board. Four of them are configuration selectors. The fifth is the sense line of the clock-output pin. Each line can be tied low, tied high, or looped back to one of two shared output pins. A plain high/low read cannot tell a loop-back from a fixed level, so the decoder drives the two shared pins through three test patterns. It waits a programmable number of settle cycles in each pattern and then samples every line. The three samples of a line place it in one of four classes.

From the classes of selectors 0 and 1 the block derives a carrier-frequency index. From selectors 2 and 3 it derives a modem profile index, with a squelch flag. From the clock-pin sense line it derives a clock-output enable and a slow-clock select. Illegal wiring raises an error flag and falls back to entry 0. The result is registered and announced with a one-cycle done strobe. After that strobe the two shared pins stop carrying patterns: their value and enable come from the mode-status and receive-data functions. The result stays frozen until the next reset.

Top module: `strap_cfg_decoder`

## Requirements
- R1: While the result is not yet valid, both shared pins are enabled and driven by the decoder. Pins (out0, out1) read (0,0) during phase 0, (1,0) during phase 1 and (0,1) during phase 2. Each phase lasts SETTLE_CYCLES cycles, counted from the first cycle after reset. Both pins then read (0,0) for one further cycle.
- R2: Each line is sampled in the last cycle of each phase. Its class is chosen in this order: high in phase 0 gives VDD. Otherwise, high in phase 1 gives OUT0. Otherwise, high in phase 2 gives OUT1. Otherwise the class is GND.
- R3: Selector pairs (sel0, sel1) map to freq_sel_o values 0 to 5 as follows: (GND,VDD)=0, (VDD,VDD)=1, (OUT1,VDD)=2, (GND,OUT1)=3, (VDD,OUT1)=4, (OUT1,OUT1)=5.
- R4: Any other frequency pair sets freq_err_o and forces freq_sel_o to 0. This covers any use of OUT0 and any pair with sel1 at GND.
- R5: The profile index is set by sel3. With sel3=GND, sel2 GND/VDD/OUT1/OUT0 gives 0/1/2/3. With sel3=VDD, sel2 GND/VDD gives 4/5. With sel3=OUT1, sel2 GND/VDD/OUT1/OUT0 gives 6/7/8/9. With sel3=OUT0, sel2 GND/VDD/OUT1 gives 10/11/12. Indices 0 to 5 are OOK profiles and 6 to 12 are FSK profiles.
- R6: The three remaining selector pairs set profile_err_o and force profile_o to 0.
- R7: squelch_o is 1 only for profiles 11 and 12.
- R8: clk_en_o is 0 when the clock-pin sense line is classed OUT0, and 1 for any other class.
- R9: clk_slow_o is 1 exactly when clk_en_o is 1 and freq_sel_o is 1 with no frequency error.
- R10: done_o is high for exactly one cycle, in cycle 3*SETTLE_CYCLES+1 after reset. cfg_valid_o rises in that same cycle and stays high.
- R11: Once cfg_valid_o is high, out0_o and out0_oe_o follow stat_i and stat_oe_i, and out1_o and out1_oe_o follow rxd_i and rxd_oe_i.
- R12: Under reset, and until cfg_valid_o rises, every decoded output is 0. After it rises, the decoded outputs do not change until the next reset, whatever the strap lines do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a new decode |
| sel_i | input | 4 | Configuration selector lines 0..3 |
| clkpin_i | input | 1 | Sense line of the clock-output pin |
| stat_i | input | 1 | Mode-status value for shared pin 0 after decode |
| stat_oe_i | input | 1 | Mode-status output enable |
| rxd_i | input | 1 | Receive-data value for shared pin 1 after decode |
| rxd_oe_i | input | 1 | Receive-data output enable |
| out0_o | output | 1 | Shared pin 0 value |
| out0_oe_o | output | 1 | Shared pin 0 output enable |
| out1_o | output | 1 | Shared pin 1 value |
| out1_oe_o | output | 1 | Shared pin 1 output enable |
| freq_sel_o | output | 3 | Carrier-frequency index |
| freq_err_o | output | 1 | Illegal frequency wiring |
| profile_o | output | 4 | Modem profile index |
| profile_err_o | output | 1 | Illegal profile wiring |
| squelch_o | output | 1 | Squelch enabled by profile |
| clk_en_o | output | 1 | Clock output enabled |
| clk_slow_o | output | 1 | Clock output uses the slower rate |
| cfg_valid_o | output | 1 | Decoded result is valid |
| done_o | output | 1 | One-cycle strobe at end of decode |

## Verification
A wrong phase counter or phase register shows up on the shared pins in the same cycle it goes wrong, because the pin pattern is a direct image of the phase. A wrong sample register or class stays hidden until cycle 3*SETTLE_CYCLES+1, when it appears as a wrong index or error flag. The bench models the strap wiring with a two-cycle lag, so sampling anywhere but the end of the phase produces a wrong class. A fault in the hold logic is seen within one cycle of the strap lines changing after done.

// File: rtl/strap_pkg.sv
// Shared types for the pin-strap decoder.
// Assumes exactly three detection phases and five sensed lines.
package strap_pkg;
    localparam int NUM_PHASE = 3;
    localparam int NUM_LINES = 5;
    localparam int FREQ_W    = 3;
    localparam int PROF_W    = 4;

    // Class of a strap line; encoding is used arithmetically by the profile table.
    typedef enum logic [1:0] {
        STRAP_GND  = 2'd0,
        STRAP_VDD  = 2'd1,
        STRAP_OUT1 = 2'd2,
        STRAP_OUT0 = 2'd3
    } strap_e;

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic              freq_err;
        logic [PROF_W-1:0] prof;
        logic              prof_err;
        logic              squelch;
        logic              clk_en;
        logic              clk_slow;
    } cfg_t;
endpackage

// File: rtl/strap_phase_seq.sv
// Phase sequencer: steps through three drive patterns of SETTLE_CYCLES each,
// flags the sampling cycle, then one finish cycle, then holds valid.
// Assumes SETTLE_CYCLES >= 1. Synchronous active-low reset.
module strap_phase_seq #(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] phase_o,
    output logic       smp_stb_o,
    output logic       fin_o,
    output logic       valid_o,
    output logic       done_o,
    output logic       pat0_o,
    output logic       pat1_o
);
    import strap_pkg::*;

    localparam int              CNT_W    = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [1:0]       PH_LAST  = 2'(NUM_PHASE - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       ph_q;
    logic             busy_q;
    logic             fin_q;
    logic             valid_q;
    logic             done_q;
    logic             last_cyc;

    // Last settle cycle of the current phase.
    assign last_cyc = busy_q && (cnt_q == CNT_LAST);

    // Advance settle counter and phase; raise finish, valid and done in turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ph_q    <= '0;
            busy_q  <= 1'b1;
            fin_q   <= 1'b0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            fin_q  <= last_cyc && (ph_q == PH_LAST);
            done_q <= fin_q;
            if (fin_q) begin
                valid_q <= 1'b1;
            end
            if (busy_q) begin
                if (cnt_q == CNT_LAST) begin
                    cnt_q <= '0;
                    if (ph_q == PH_LAST) begin
                        busy_q <= 1'b0;
                    end else begin
                        ph_q <= ph_q + 2'd1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign phase_o   = ph_q;
    assign smp_stb_o = last_cyc;
    assign fin_o     = fin_q;
    assign valid_o   = valid_q;
    assign done_o    = done_q;
    // Pattern per phase: phase 1 raises pin 0, phase 2 raises pin 1.
    assign pat0_o    = busy_q && (ph_q == 2'd1);
    assign pat1_o    = busy_q && (ph_q == 2'd2);
endmodule

// File: rtl/strap_sampler.sv
// Per-line sampler: captures one bit per phase on the sampling strobe and
// classifies each line as GND, VDD, OUT0 or OUT1 from the three bits.
// Assumes the phase order (0,0), (1,0), (0,1) on (out0, out1).
module strap_sampler #(
    parameter int NUM_LINES = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_LINES-1:0]             line_i,
    input  logic                             smp_stb_i,
    input  logic [1:0]                       phase_i,
    output strap_pkg::strap_e [NUM_LINES-1:0] class_o
);
    import strap_pkg::*;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [NUM_PHASE-1:0] smp_q;

        // Store this line's level in the bit of the phase being sampled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                smp_q <= '0;
            end else begin
                for (int p = 0; p < NUM_PHASE; p++) begin
                    if (smp_stb_i && (phase_i == 2'(p))) begin
                        smp_q[p] <= line_i[g];
                    end
                end
            end
        end

        // A fixed level wins; otherwise the pin the line followed.
        assign class_o[g] = smp_q[0] ? STRAP_VDD  :
                            smp_q[1] ? STRAP_OUT0 :
                            smp_q[2] ? STRAP_OUT1 : STRAP_GND;
    end
endmodule

// File: rtl/strap_table.sv
// Decode table: turns line classes into frequency index, profile index,
// squelch, clock enable and clock rate, with error fallback to entry 0.
// Purely combinational.
module strap_table (
    input  strap_pkg::strap_e sel0_i,
    input  strap_pkg::strap_e sel1_i,
    input  strap_pkg::strap_e sel2_i,
    input  strap_pkg::strap_e sel3_i,
    input  strap_pkg::strap_e clkpin_i,
    output strap_pkg::cfg_t   cfg_o
);
    import strap_pkg::*;

    logic [FREQ_W-1:0] freq;
    logic              ferr;
    logic [PROF_W-1:0] prof;
    logic              perr;

    // Frequency index from the selector 0/1 pair.
    always_comb begin
        freq = '0;
        ferr = 1'b0;
        unique case (sel1_i)
            STRAP_VDD: begin
                case (sel0_i)
                    STRAP_GND:  freq = 3'd0;
                    STRAP_VDD:  freq = 3'd1;
                    STRAP_OUT1: freq = 3'd2;
                    default:    ferr = 1'b1;
                endcase
            end
            STRAP_OUT1: begin
                case (sel0_i)
                    STRAP_GND:  freq = 3'd3;
                    STRAP_VDD:  freq = 3'd4;
                    STRAP_OUT1: freq = 3'd5;
                    default:    ferr = 1'b1;
                endcase
            end
            default: ferr = 1'b1;
        endcase
    end

    // Profile index: base per selector 3 class plus selector 2 class.
    always_comb begin
        prof = '0;
        perr = 1'b0;
        unique case (sel3_i)
            STRAP_GND:  prof = {2'b00, sel2_i};
            STRAP_VDD: begin
                if (sel2_i == STRAP_GND || sel2_i == STRAP_VDD) prof = 4'd4 + {2'b00, sel2_i};
                else perr = 1'b1;
            end
            STRAP_OUT1: prof = 4'd6 + {2'b00, sel2_i};
            default: begin
                if (sel2_i != STRAP_OUT0) prof = 4'd10 + {2'b00, sel2_i};
                else perr = 1'b1;
            end
        endcase
    end

    // Assemble the result record.
    always_comb begin
        cfg_o.freq     = freq;
        cfg_o.freq_err = ferr;
        cfg_o.prof     = prof;
        cfg_o.prof_err = perr;
        cfg_o.squelch  = !perr && (prof >= 4'd11);
        cfg_o.clk_en   = (clkpin_i != STRAP_OUT0);
        cfg_o.clk_slow = (clkpin_i != STRAP_OUT0) && !ferr && (freq == 3'd1);
    end
endmodule

// File: rtl/strap_cfg_decoder.sv
// Top of the pin-strap decoder. Owns the two shared pins until the result
// is valid, then hands them to the status and data functions. The result is
// registered in the finish cycle and held until the next reset.
// Synchronous active-low reset restarts detection.
module strap_cfg_decoder #(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sel_i,
    input  logic       clkpin_i,
    input  logic       stat_i,
    input  logic       stat_oe_i,
    input  logic       rxd_i,
    input  logic       rxd_oe_i,
    output logic       out0_o,
    output logic       out0_oe_o,
    output logic       out1_o,
    output logic       out1_oe_o,
    output logic [2:0] freq_sel_o,
    output logic       freq_err_o,
    output logic [3:0] profile_o,
    output logic       profile_err_o,
    output logic       squelch_o,
    output logic       clk_en_o,
    output logic       clk_slow_o,
    output logic       cfg_valid_o,
    output logic       done_o
);
    import strap_pkg::*;

    logic [1:0]                 phase;
    logic                       smp_stb;
    logic                       fin;
    logic                       valid;
    logic                       pat0;
    logic                       pat1;
    logic [NUM_LINES-1:0]       lines;
    strap_e [NUM_LINES-1:0]     cls;
    cfg_t                       cfg_next;
    cfg_t                       cfg_q;

    assign lines = {clkpin_i, sel_i};

    strap_phase_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_o   (phase),
        .smp_stb_o (smp_stb),
        .fin_o     (fin),
        .valid_o   (valid),
        .done_o    (done_o),
        .pat0_o    (pat0),
        .pat1_o    (pat1)
    );

    strap_sampler #(.NUM_LINES(NUM_LINES)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (lines),
        .smp_stb_i (smp_stb),
        .phase_i   (phase),
        .class_o   (cls)
    );

    strap_table u_tbl (
        .sel0_i   (cls[0]),
        .sel1_i   (cls[1]),
        .sel2_i   (cls[2]),
        .sel3_i   (cls[3]),
        .clkpin_i (cls[4]),
        .cfg_o    (cfg_next)
    );

    // Capture the decoded record once, in the finish cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (fin) begin
            cfg_q <= cfg_next;
        end
    end

    // Shared pins: test patterns while decoding, normal functions afterwards.
    always_comb begin
        if (valid) begin
            out0_o    = stat_i;
            out0_oe_o = stat_oe_i;
            out1_o    = rxd_i;
            out1_oe_o = rxd_oe_i;
        end else begin
            out0_o    = pat0;
            out0_oe_o = 1'b1;
            out1_o    = pat1;
            out1_oe_o = 1'b1;
        end
    end

    assign freq_sel_o    = cfg_q.freq;
    assign freq_err_o    = cfg_q.freq_err;
    assign profile_o     = cfg_q.prof;
    assign profile_err_o = cfg_q.prof_err;
    assign squelch_o     = cfg_q.squelch;
    assign clk_en_o      = cfg_q.clk_en;
    assign clk_slow_o    = cfg_q.clk_slow;
    assign cfg_valid_o   = valid;
endmodule

// File: rtl/strap_cfg_checker.sv
// Port-level properties of the strap decoder, bound to the top module.
module strap_cfg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       out0_o,
    input logic       out0_oe_o,
    input logic       out1_o,
    input logic       out1_oe_o,
    input logic [2:0] freq_sel_o,
    input logic       freq_err_o,
    input logic [3:0] profile_o,
    input logic       profile_err_o,
    input logic       squelch_o,
    input logic       clk_en_o,
    input logic       clk_slow_o,
    input logic       cfg_valid_o,
    input logic       done_o
);
    // R1
    owned_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid_o |-> (out0_oe_o && out1_oe_o && !(out0_o && out1_o)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid_o) |-> done_o);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |=> (cfg_valid_o && $stable(freq_sel_o) && $stable(profile_o)
                         && $stable({freq_err_o, profile_err_o, squelch_o, clk_en_o, clk_slow_o})));

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid_o |-> (freq_sel_o == 3'd0 && profile_o == 4'd0 && !freq_err_o
                          && !profile_err_o && !squelch_o && !clk_en_o && !clk_slow_o));

    // R3
    freq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_sel_o <= 3'd5);

    // R4
    freq_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_err_o |-> freq_sel_o == 3'd0);

    // R6
    prof_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        profile_err_o |-> profile_o == 4'd0);

    // R7
    squelch_prof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squelch_o |-> (profile_o >= 4'd11 && profile_o <= 4'd12));

    // R9
    slow_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_slow_o |-> (clk_en_o && freq_sel_o == 3'd1));
endmodule

bind strap_cfg_decoder strap_cfg_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .out0_o        (out0_o),
    .out0_oe_o     (out0_oe_o),
    .out1_o        (out1_o),
    .out1_oe_o     (out1_oe_o),
    .freq_sel_o    (freq_sel_o),
    .freq_err_o    (freq_err_o),
    .profile_o     (profile_o),
    .profile_err_o (profile_err_o),
    .squelch_o     (squelch_o),
    .clk_en_o      (clk_en_o),
    .clk_slow_o    (clk_slow_o),
    .cfg_valid_o   (cfg_valid_o),
    .done_o        (done_o)
);

// File: tb/strap_cfg_decoder_bench.sv
module strap_cfg_decoder_bench;
    localparam int S = 4;
    // Line classes in the bench: 0 GND, 1 VDD, 2 OUT1, 3 OUT0.
    localparam int GND = 0, VDD = 1, O1 = 2, O0 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] sel_i;
    logic clkpin_i;
    logic stat_i = 1'b1, stat_oe_i = 1'b0, rxd_i = 1'b1, rxd_oe_i = 1'b0;
    logic out0_o, out0_oe_o, out1_o, out1_oe_o;
    logic [2:0] freq_sel_o;
    logic [3:0] profile_o;
    logic freq_err_o, profile_err_o, squelch_o, clk_en_o, clk_slow_o, cfg_valid_o, done_o;

    int n_chk = 0;
    int n_fail = 0;
    int cls [5];
    logic [4:0] raw, lag1, lag2;

    always #4 clk = ~clk;

    strap_cfg_decoder #(.SETTLE_CYCLES(S)) u_strap_cfg_decoder (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .clkpin_i(clkpin_i),
        .stat_i(stat_i), .stat_oe_i(stat_oe_i), .rxd_i(rxd_i), .rxd_oe_i(rxd_oe_i),
        .out0_o(out0_o), .out0_oe_o(out0_oe_o), .out1_o(out1_o), .out1_oe_o(out1_oe_o),
        .freq_sel_o(freq_sel_o), .freq_err_o(freq_err_o), .profile_o(profile_o),
        .profile_err_o(profile_err_o), .squelch_o(squelch_o), .clk_en_o(clk_en_o),
        .clk_slow_o(clk_slow_o), .cfg_valid_o(cfg_valid_o), .done_o(done_o)
    );

    // Board model: each line follows its tie, seen through a two-cycle lag
    // (series resistor), so only late-phase sampling classifies it right (R2).
    always_comb begin
        for (int i = 0; i < 5; i++) begin
            case (cls[i])
                GND:     raw[i] = 1'b0;
                VDD:     raw[i] = 1'b1;
                O1:      raw[i] = out1_o;
                default: raw[i] = out0_o;
            endcase
        end
    end
    always_ff @(posedge clk) begin
        lag1 <= raw;
        lag2 <= lag1;
    end
    assign sel_i    = lag2[3:0];
    assign clkpin_i = lag2[4];

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Expected frequency index, -1 when illegal.
    function automatic int ref_freq(input int a, input int b);
        int pa [6] = '{GND, VDD, O1, GND, VDD, O1};
        int pb [6] = '{VDD, VDD, VDD, O1, O1, O1};
        for (int k = 0; k < 6; k++) if (pa[k] == a && pb[k] == b) return k;
        return -1;
    endfunction

    // Expected profile index, -1 when illegal.
    function automatic int ref_prof(input int a, input int b);
        int pa [13] = '{GND, VDD, O1, O0, GND, VDD, GND, VDD, O1, O0, GND, VDD, O1};
        int pb [13] = '{GND, GND, GND, GND, VDD, VDD, O1, O1, O1, O1, O0, O0, O0};
        for (int k = 0; k < 13; k++) if (pa[k] == a && pb[k] == b) return k;
        return -1;
    endfunction

    task automatic run_case(input int s0, input int s1, input int s2, input int s3, input int ck);
        int ef, ep, e_f, e_fe, e_p, e_pe, e_sq, e_ce, e_cs;
        bit v;
        @(negedge clk);
        cls[0] = s0; cls[1] = s1; cls[2] = s2; cls[3] = s3; cls[4] = ck;
        stat_i = 1'b1; stat_oe_i = 1'b0; rxd_i = 1'b1; rxd_oe_i = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ef = ref_freq(s0, s1);
        ep = ref_prof(s2, s3);
        e_fe = (ef < 0); e_f = (ef < 0) ? 0 : ef;
        e_pe = (ep < 0); e_p = (ep < 0) ? 0 : ep;
        e_sq = (ep == 11 || ep == 12);
        e_ce = (ck != O0);
        e_cs = e_ce && (ef == 1);
        for (int c = 0; c <= 3 * S + 4; c++) begin
            #2;
            v = (c >= 3 * S + 1);
            if (c == 0) begin
                chk("R12 reset valid", cfg_valid_o, 0);
                chk("R12 reset done", done_o, 0);
            end
            chk("R10 valid", cfg_valid_o, v);
            chk("R10 done", done_o, c == 3 * S + 1);
            if (!v) begin
                chk("R1 out0", out0_o, (c < 3 * S) && (c / S == 1));
                chk("R1 out1", out1_o, (c < 3 * S) && (c / S == 2));
                chk("R1 oe", {out0_oe_o, out1_oe_o}, 3);
            end else begin
                chk("R11 out0", {out0_o, out0_oe_o}, {stat_i, stat_oe_i});
                chk("R11 out1", {out1_o, out1_oe_o}, {rxd_i, rxd_oe_i});
            end
            chk("R3 freq (R2)", freq_sel_o, v ? e_f : 0);
            chk("R4 freq_err", freq_err_o, v ? e_fe : 0);
            chk("R5 profile (R2)", profile_o, v ? e_p : 0);
            chk("R6 profile_err", profile_err_o, v ? e_pe : 0);
            chk("R7 squelch", squelch_o, v ? e_sq : 0);
            chk("R8 clk_en", clk_en_o, v ? e_ce : 0);
            chk("R9 clk_slow", clk_slow_o, v ? e_cs : 0);
            @(negedge clk);
        end
        // After done: rewire straps and toggle the normal pin functions.
        cls[0] = (s0 + 1) % 4; cls[1] = (s1 + 2) % 4; cls[2] = (s2 + 3) % 4;
        cls[3] = (s3 + 1) % 4; cls[4] = (ck + 1) % 4;
        for (int h = 0; h < 8; h++) begin
            stat_i = h[0]; stat_oe_i = h[1]; rxd_i = ~h[0]; rxd_oe_i = h[2];
            #2;
            chk("R11 out0 pass", {out0_o, out0_oe_o}, {stat_i, stat_oe_i});
            chk("R11 out1 pass", {out1_o, out1_oe_o}, {rxd_i, rxd_oe_i});
            chk("R12 hold freq", {freq_err_o, freq_sel_o}, {e_fe[0], e_f[2:0]});
            chk("R12 hold prof", {profile_err_o, profile_o}, {e_pe[0], e_p[3:0]});
            chk("R12 hold misc", {squelch_o, clk_en_o, clk_slow_o, cfg_valid_o, done_o},
                {e_sq[0], e_ce[0], e_cs[0], 1'b1, 1'b0});
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 5; i++) cls[i] = GND;
        repeat (3) @(negedge clk);
        run_case(GND, VDD, GND, GND, GND);
        run_case(VDD, VDD, VDD, VDD, VDD);
        run_case(O1,  VDD, O0,  GND, O1);
        run_case(GND, O1,  GND, O1,  O0);
        run_case(VDD, O1,  VDD, O0,  VDD);
        run_case(O1,  O1,  O1,  O0,  GND);
        run_case(O0,  VDD, O1,  VDD, VDD);
        run_case(GND, GND, O0,  O0,  O1);
        run_case(VDD, GND, O0,  O1,  GND);
        run_case(VDD, VDD, O0,  O1,  O0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule